// File: doc/BRIEF.md
# Virtio PCI interrupt status controller

This block produces the interrupt signalling of a virtio device attached over PCI. The device core gives it single-cycle event pulses: one for a change of device configuration and one per virtqueue for a queue notification. The block keeps a byte-wide interrupt status register. The host reads it through a one-cycle read strobe, and that same read clears it. While MSI-X is off, the block drives a level-sensitive legacy INTx line.

While MSI-X is on, each event becomes a message request carrying an MSI-X table entry number, unless that number is the no-vector value 16'hFFFF. Configuration changes use the configuration vector and queue events use their own queue's vector. Requests leave over a valid/ready handshake. Events that fire while earlier requests are still waiting are first latched per source and then queued in a small first-in first-out buffer. The configuration flag is set in both modes, so a driver using MSI-X can still read the status byte to see that configuration changed.

Top module: `vio_irq_ctrl`

## Requirements
- R1: After reset, the status byte reads 8'h00, `intx_o` is low and `msg_valid_o` is low.
- R2: A read strobe returns the current status byte in that cycle on `isr_rdata_o`. From the next cycle the whole byte is zero and `intx_o` is low, provided no event arrives in the read cycle.
- R3: Status bit 0 is the queue flag and bit 1 is the configuration flag; bits 7..2 always read as zero.
- R4: A configuration event sets bit 1 in the next cycle whether MSI-X is enabled or not.
- R5: A queue event sets bit 0 only while MSI-X is disabled; with MSI-X enabled it leaves bit 0 unchanged.
- R6: While MSI-X is disabled, `intx_o` equals the OR of the status bits; while it is enabled, `intx_o` is low.
- R7: If an event arrives in the cycle of a read, the read returns the old byte and the new event's bit is set afterwards.
- R8: With MSI-X enabled, a configuration event requests one message whose `msg_vec_o` equals `cfg_vec_i`; no message is requested if that vector is 16'hFFFF, or if MSI-X is disabled.
- R9: With MSI-X enabled, an event on queue i requests a message carrying that queue's vector, `q_vec_i[16*i +: 16]`, under the same 16'hFFFF no-vector rule.
- R10: Once `msg_valid_o` is high it stays high, with `msg_vec_o` unchanged, until a cycle with `msg_ready_i` high.
- R11: No message request is lost while the buffer is full. Requests are delivered in arrival order, and requests from the same cycle go configuration first, then ascending queue index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msix_en_i | input | 1 | MSI-X enabled |
| cfg_evt_i | input | 1 | Configuration-change event pulse |
| q_evt_i | input | NUM_Q | Per-queue notification pulses |
| cfg_vec_i | input | VEC_W | MSI-X table entry for configuration changes |
| q_vec_i | input | NUM_Q*VEC_W | Per-queue MSI-X table entries, queue i at bits VEC_W*i upward |
| isr_rd_i | input | 1 | Status read strobe (read clears) |
| isr_rdata_o | output | 8 | Status byte |
| intx_o | output | 1 | Legacy level interrupt |
| msg_valid_o | output | 1 | MSI-X message request valid |
| msg_ready_i | input | 1 | MSI-X message request accepted |
| msg_vec_o | output | VEC_W | Table entry number of the request |

## Verification
The embedded properties check several rules on every cycle: the configuration flag sets after its event, queue events leave bit 0 alone under MSI-X, a read without a concurrent event empties the byte, a waiting request holds its valid and vector, the buffer is never pushed when full, and no request carries the no-vector value. The directed scenarios are needed for the rest. These are the exact value a read returns when it coincides with an event, the mapping from sources to table entries, suppression of messages for the no-vector value and in legacy mode, and the delivery order of requests that piled up behind a stalled handshake.

// File: rtl/vio_irq_pkg.sv
package vio_irq_pkg;
  localparam int unsigned VEC_W     = 16;
  localparam logic [VEC_W-1:0] NO_VEC = 16'hFFFF;
  localparam int unsigned Q_BIT     = 0;
  localparam int unsigned CFG_BIT   = 1;
endpackage

// File: rtl/vio_isr_reg.sv
module vio_isr_reg
  import vio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       msix_en_i,
  input  logic       cfg_evt_i,
  input  logic       q_any_i,
  input  logic       rd_i,
  output logic [7:0] isr_o,
  output logic       intx_o
);
  logic q_flag_q, cfg_flag_q;
  logic q_flag_d, cfg_flag_d;

  // read clears, but a same-cycle event survives
  always_comb begin
    q_flag_d   = (q_flag_q & ~rd_i) | (q_any_i & ~msix_en_i);
    cfg_flag_d = (cfg_flag_q & ~rd_i) | cfg_evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_flag_q   <= 1'b0;
      cfg_flag_q <= 1'b0;
    end else begin
      q_flag_q   <= q_flag_d;
      cfg_flag_q <= cfg_flag_d;
    end
  end

  always_comb begin
    isr_o          = '0;
    isr_o[Q_BIT]   = q_flag_q;
    isr_o[CFG_BIT] = cfg_flag_q;
  end

  assign intx_o = ~msix_en_i & (q_flag_q | cfg_flag_q);

  p_cfg_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_evt_i |=> isr_o[CFG_BIT]);
  p_q_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msix_en_i && !isr_o[Q_BIT]) |=> !isr_o[Q_BIT]);
  p_rd_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !cfg_evt_i && !q_any_i) |=> (isr_o == 8'h00));
endmodule

// File: rtl/vio_msg_fifo.sv
module vio_msg_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_ptr_q, rd_ptr_q;
  logic         empty, pop;

  assign empty   = (wr_ptr_q == rd_ptr_q);
  assign full_o  = (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]) && (wr_ptr_q[AW] != rd_ptr_q[AW]);
  assign valid_o = ~empty;
  assign data_o  = mem_q[rd_ptr_q[AW-1:0]];
  assign pop     = valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)    rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q[AW-1:0]] <= data_i;
  end

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/vio_msg_arb.sv
module vio_msg_arb #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned W       = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   req_i,
  input  logic [NUM_SRC*W-1:0] vec_i,
  input  logic                 full_i,
  output logic                 push_o,
  output logic [W-1:0]         vec_o
);
  localparam int unsigned SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend_q, grant;
  logic [SW-1:0]      sel;

  // lowest index wins: configuration is source 0
  always_comb begin
    sel = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = SW'(i);
    end
  end

  assign push_o = (|pend_q) & ~full_i;
  assign grant  = push_o ? (NUM_SRC'(1) << sel) : '0;
  assign vec_o  = vec_i[sel*W +: W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~grant) | req_i;
  end
endmodule

// File: rtl/vio_irq_ctrl.sv
module vio_irq_ctrl
  import vio_irq_pkg::*;
#(
  parameter int unsigned NUM_Q      = 4,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   msix_en_i,
  input  logic                   cfg_evt_i,
  input  logic [NUM_Q-1:0]       q_evt_i,
  input  logic [VEC_W-1:0]       cfg_vec_i,
  input  logic [NUM_Q*VEC_W-1:0] q_vec_i,
  input  logic                   isr_rd_i,
  output logic [7:0]             isr_rdata_o,
  output logic                   intx_o,
  output logic                   msg_valid_o,
  input  logic                   msg_ready_i,
  output logic [VEC_W-1:0]       msg_vec_o
);
  localparam int unsigned NUM_SRC = NUM_Q + 1;

  logic [NUM_SRC-1:0]       src_req;
  logic [NUM_SRC*VEC_W-1:0] src_vec;
  logic                     fifo_full, push;
  logic [VEC_W-1:0]         push_vec;

  assign src_vec[VEC_W-1:0] = cfg_vec_i;
  assign src_req[0] = cfg_evt_i & msix_en_i & (cfg_vec_i != NO_VEC);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_qsrc
    assign src_vec[(g+1)*VEC_W +: VEC_W] = q_vec_i[g*VEC_W +: VEC_W];
    assign src_req[g+1] = q_evt_i[g] & msix_en_i & (q_vec_i[g*VEC_W +: VEC_W] != NO_VEC);
  end

  vio_isr_reg i_isr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .msix_en_i (msix_en_i),
    .cfg_evt_i (cfg_evt_i),
    .q_any_i   (|q_evt_i),
    .rd_i      (isr_rd_i),
    .isr_o     (isr_rdata_o),
    .intx_o    (intx_o)
  );

  vio_msg_arb #(.NUM_SRC(NUM_SRC), .W(VEC_W)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (src_req),
    .vec_i  (src_vec),
    .full_i (fifo_full),
    .push_o (push),
    .vec_o  (push_vec)
  );

  vio_msg_fifo #(.W(VEC_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (push_vec),
    .full_o  (fifo_full),
    .valid_o (msg_valid_o),
    .ready_i (msg_ready_i),
    .data_o  (msg_vec_o)
  );

  p_no_novec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_vec_o != NO_VEC));
endmodule

// File: tb/test_vio_irq_ctrl.sv
module test_vio_irq_ctrl;
  localparam int NQ = 4;
  localparam logic [15:0] CV = 16'h0005;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msix_en = 1'b0, cfg_evt = 1'b0, rd = 1'b0, ready = 1'b0;
  logic [NQ-1:0] q_evt = '0;
  logic [15:0] cfg_vec = CV;
  logic [NQ*16-1:0] q_vec;
  logic [7:0] rdata;
  logic intx, valid;
  logic [15:0] vec;

  int errors = 0, checks = 0, got_n = 0;
  logic [15:0] got [64];
  bit done = 0;

  always #2 clk = ~clk;

  vio_irq_ctrl #(.NUM_Q(NQ), .FIFO_DEPTH(4)) i_vio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .msix_en_i(msix_en), .cfg_evt_i(cfg_evt),
    .q_evt_i(q_evt), .cfg_vec_i(cfg_vec), .q_vec_i(q_vec), .isr_rd_i(rd),
    .isr_rdata_o(rdata), .intx_o(intx), .msg_valid_o(valid),
    .msg_ready_i(ready), .msg_vec_o(vec)
  );

  always @(posedge clk) begin
    if (rst_n && valid && ready && got_n < 64) begin
      got[got_n] <= vec;
      got_n <= got_n + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_clear(string req, logic [7:0] exp);
    rd = 1'b1;
    #0 chk(req, rdata, exp);
    cyc(1);
    rd = 1'b0;
    chk(req, rdata, 8'h00);
    chk(req, intx, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 status", rdata, 8'h00);
    chk("R1 intx", intx, 1'b0);
    chk("R1 valid", valid, 1'b0);
  endtask

  task automatic t_legacy;
    int base = got_n;
    msix_en = 1'b0; ready = 1'b1;
    q_evt[2] = 1'b1; cyc(1); q_evt = '0;
    chk("R5 legacy queue bit", rdata, 8'h01);
    chk("R6 intx legacy", intx, 1'b1);
    read_clear("R2 read clears queue", 8'h01);
    cfg_evt = 1'b1; cyc(1); cfg_evt = 1'b0;
    chk("R3 cfg bit position", rdata, 8'h02);
    chk("R6 intx cfg", intx, 1'b1);
    read_clear("R2 read clears cfg", 8'h02);
    cyc(5);
    chk("R8 no message in legacy mode", got_n - base, 0);
  endtask

  task automatic t_msix;
    int base = got_n;
    msix_en = 1'b1; ready = 1'b1;
    q_evt[1] = 1'b1; cyc(1); q_evt = '0;
    chk("R5 queue bit not set under MSI-X", rdata, 8'h00);
    cfg_evt = 1'b1; cyc(1); cfg_evt = 1'b0;
    chk("R4 cfg bit set under MSI-X", rdata, 8'h02);
    chk("R6 intx low under MSI-X", intx, 1'b0);
    cyc(6);
    chk("R9 count", got_n - base, 2);
    chk("R9 queue 1 vector", got[base], 16'h0011);
    chk("R8 cfg vector", got[base+1], CV);
    read_clear("R2 read under MSI-X", 8'h02);
  endtask

  task automatic t_novec;
    int base = got_n;
    msix_en = 1'b1; ready = 1'b1;
    cfg_vec = 16'hFFFF;
    cfg_evt = 1'b1; cyc(1); cfg_evt = 1'b0;
    chk("R4 cfg bit with no vector", rdata, 8'h02);
    q_vec[3*16 +: 16] = 16'hFFFF;
    q_evt[3] = 1'b1; cyc(1); q_evt = '0;
    cyc(6);
    chk("R8 R9 no message for no-vector", got_n - base, 0);
    cfg_vec = CV; q_vec[3*16 +: 16] = 16'h0013;
    read_clear("R2 cleanup", 8'h02);
  endtask

  task automatic t_collide;
    msix_en = 1'b0;
    q_evt[0] = 1'b1; cyc(1); q_evt = '0;
    rd = 1'b1; cfg_evt = 1'b1;
    #0 chk("R7 read returns old", rdata, 8'h01);
    cyc(1);
    rd = 1'b0; cfg_evt = 1'b0;
    chk("R7 new cfg bit kept", rdata, 8'h02);
    chk("R7 intx still high", intx, 1'b1);
    rd = 1'b1; q_evt[0] = 1'b1;
    #0 chk("R7 read returns old 2", rdata, 8'h02);
    cyc(1);
    rd = 1'b0; q_evt = '0;
    chk("R7 new queue bit kept", rdata, 8'h01);
    read_clear("R2 cleanup", 8'h01);
  endtask

  task automatic t_backpressure;
    int base = got_n;
    logic [15:0] exp [5];
    msix_en = 1'b1; ready = 1'b0;
    cfg_evt = 1'b1; cyc(1); cfg_evt = 1'b0;
    cyc(2);
    chk("R10 valid raised", valid, 1'b1);
    for (int i = 0; i < 4; i++) begin
      cyc(1);
      chk("R10 valid held", valid, 1'b1);
      chk("R10 vector held", vec, CV);
    end
    cfg_evt = 1'b1; q_evt = 4'b0101; cyc(1); cfg_evt = 1'b0; q_evt = '0;
    cyc(4);
    q_evt[1] = 1'b1; cyc(1); q_evt = '0;
    cyc(4);
    chk("R11 nothing taken while stalled", got_n - base, 0);
    ready = 1'b1;
    cyc(12);
    exp[0] = CV; exp[1] = CV; exp[2] = 16'h0010; exp[3] = 16'h0012; exp[4] = 16'h0011;
    chk("R11 count none lost", got_n - base, 5);
    for (int i = 0; i < 5; i++) chk("R11 order", got[base+i], exp[i]);
    chk("R10 valid drops when drained", valid, 1'b0);
    read_clear("R2 cleanup", 8'h02);
  endtask

  initial begin
    for (int i = 0; i < NQ; i++) q_vec[i*16 +: 16] = 16'h0010 + 16'(i);
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_legacy();
    t_msix();
    t_novec();
    t_collide();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule